// File: doc/BRIEF.md
# Addressed Serial Control Register

This block holds the ten-bit configuration word of a converter-style peripheral whose serial port shares a bus with one other device. A host shifts a control word in on a serial data line, one bit per falling edge of the serial clock, most significant bit first. It then drops the active-low write-frame strobe. On that falling edge the block compares the word's address bit with a hardwired strap pin. A matching word is committed to the configuration outputs. A word that does not match leaves the configuration untouched.

Every committed word makes this device the owner of the shared read-data line. A word addressed to the companion device takes ownership away. While it owns the line and the read frame is active, the block raises the output enable for its serial data driver. The input-configuration bits are decoded into a two-bit input-mode code and a three-bit channel code. The convert-request bit is passed on to an external sequencer, which clears it by pulsing a done input. All serial pins are synchronised into the system clock domain. The reset is asynchronous on assertion and is released synchronously.

Top module: `addr_serial_cfg`

## Requirements
- R1: After reset, every configuration output is zero. pwr_mode = 2'b00 means full power-down. bus_owner, sdo_oe and wr_accept are also low.
- R2: A bit is taken from sdin on each falling edge of sclk, MSB first. The last ten bits before the wr_frame_n falling edge form the word. Extra earlier bits are discarded. Field layout: bit 9 is the address, bits 8:7 are pwr_mode, bit 6 selects input 8 as the reference, bit 5 selects pairs, bits 4:2 are the channel, bit 1 is the convert request and bit 0 is the external-reference flag.
- R3: A word whose bit 9 equals addr_pin is committed on the falling edge of wr_frame_n. In the cycle the outputs take the new value, wr_accept is high for exactly one cycle.
- R4: The configuration outputs keep their value until another matching word is committed. The one exception is the convert request, which conv_done may clear.
- R5: A word whose bit 9 differs from addr_pin changes no configuration output and produces no wr_accept pulse.
- R6: Each committed word sets bus_owner. Each word that is framed but rejected clears bus_owner.
- R7: in_mode is 2'b10 (paired) whenever bit 5 is 1, whatever bit 6 holds. Otherwise in_mode is 2'b01 when bit 6 is 1 and 2'b00 (single-ended) when bit 6 is 0. chan_sel equals bits 4:2.
- R8: A conv_done pulse clears conv_req. If a commit with bit 1 set falls in the same cycle as conv_done, the new word wins and conv_req stays 1.
- R9: sdo_oe is high only while bus_owner is high and rd_frame_n is low. A write committed while rd_frame_n is held low raises sdo_oe in the same cycle as wr_accept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial control data, MSB first |
| wr_frame_n | input | 1 | Active-low write frame; its falling edge commits the word |
| rd_frame_n | input | 1 | Active-low read frame |
| addr_pin | input | 1 | Hardwired device address strap |
| conv_done | input | 1 | Pulse from the sequencer that clears the convert request |
| pwr_mode | output | 2 | Power-mode field |
| ext_ref | output | 1 | External-reference select |
| conv_req | output | 1 | Pending convert request |
| in_mode | output | 2 | Decoded input mode |
| chan_sel | output | 3 | Channel code |
| wr_accept | output | 1 | One-cycle pulse when a matching word is committed |
| bus_owner | output | 1 | This device received the last valid word |
| sdo_oe | output | 1 | Output enable for the shared serial data driver |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a commit and an active read frame. The bench holds rd_frame_n low across a write frame and checks that sdo_oe rises together with wr_accept. It also holds rd_frame_n low across a word addressed to the other device and checks that sdo_oe drops at that edge. The second pair is a commit and the sequencer's done pulse. The bench counts the synchroniser edges after lowering the strobe and places conv_done exactly on the commit edge, then expects conv_req to stay set. Every accepted word is pushed to a scoreboard queue and compared field by field when wr_accept appears.

// File: rtl/ascr_pkg.sv
package ascr_pkg;

  localparam int CFG_W = 10;

  typedef enum logic [1:0] {
    IN_SINGLE = 2'b00,
    IN_REF8   = 2'b01,
    IN_PAIRED = 2'b10
  } in_mode_e;

  // Field order is the order in which bits arrive, MSB first.
  typedef struct packed {
    logic       dev_addr;
    logic [1:0] pwr;
    logic       ref8;
    logic       paired;
    logic [2:0] chan;
    logic       conv;
    logic       ext;
  } cfg_t;

endpackage

// File: rtl/ascr_sync.sv
module ascr_sync #(
  parameter int             N       = 4,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] fall
);

  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] prev_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      logic [N-1:0] stg_d;
      if (i == 0) begin : g_first
        always_comb stg_d = d;
      end else begin : g_rest
        always_comb stg_d = stg_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= stg_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stg_q[STAGES-1];
  end

  always_comb begin
    q    = stg_q[STAGES-1];
    fall = prev_q & ~stg_q[STAGES-1];
  end

endmodule

// File: rtl/ascr_shift.sv
module ascr_shift #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);

  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

endmodule

// File: rtl/ascr_commit.sv
module ascr_commit
  import ascr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic commit_stb,
  input  cfg_t word_in,
  input  logic addr_pin,
  input  logic conv_done,
  input  logic rd_active,
  output cfg_t cfg,
  output logic acc,
  output logic owner,
  output logic oe
);

  cfg_t cfg_q, cfg_d;
  logic acc_q, acc_d;
  logic owner_q, owner_d;
  logic oe_q, oe_d;
  logic addr_hit;

  always_comb begin
    addr_hit = (word_in.dev_addr == addr_pin);
    cfg_d    = cfg_q;
    acc_d    = 1'b0;
    owner_d  = owner_q;
    if (conv_done) cfg_d.conv = 1'b0;
    if (commit_stb) begin
      if (addr_hit) begin
        cfg_d   = word_in;
        acc_d   = 1'b1;
        owner_d = 1'b1;
      end else begin
        owner_d = 1'b0;
      end
    end
    oe_d = owner_d & rd_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      acc_q   <= 1'b0;
      owner_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      acc_q   <= acc_d;
      owner_q <= owner_d;
      oe_q    <= oe_d;
    end
  end

  assign cfg   = cfg_q;
  assign acc   = acc_q;
  assign owner = owner_q;
  assign oe    = oe_q;

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_q |-> $stable({cfg_q.dev_addr, cfg_q.pwr, cfg_q.ref8, cfg_q.paired,
                        cfg_q.chan, cfg_q.ext}));
  // R3
  acc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> !acc_q);
  // R6
  own_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> owner_q);
  // R6
  own_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owner_q) |-> acc_q);
  // R8
  conv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !commit_stb) |=> !cfg_q.conv);
  // R9
  oe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (owner_q && $past(rd_active)));

endmodule

// File: rtl/ascr_decode.sv
module ascr_decode
  import ascr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cfg_t       cfg,
  output logic [1:0] in_mode,
  output logic [2:0] chan
);

  in_mode_e mode;

  always_comb begin
    if (cfg.paired)    mode = IN_PAIRED;
    else if (cfg.ref8) mode = IN_REF8;
    else               mode = IN_SINGLE;
    in_mode = mode;
    chan    = cfg.chan;
  end

  // R7
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_mode != 2'b11);

endmodule

// File: rtl/addr_serial_cfg.sv
module addr_serial_cfg
  import ascr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       sdin,
  input  logic       wr_frame_n,
  input  logic       rd_frame_n,
  input  logic       addr_pin,
  input  logic       conv_done,
  output logic [1:0] pwr_mode,
  output logic       ext_ref,
  output logic       conv_req,
  output logic [1:0] in_mode,
  output logic [2:0] chan_sel,
  output logic       wr_accept,
  output logic       bus_owner,
  output logic       sdo_oe
);

  localparam int PIN_N = 4;
  localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1110;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [PIN_N-1:0] pin_raw, pin_lvl, pin_fall;
  logic [CFG_W-1:0] shift_word;
  cfg_t             word_in, cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign pin_raw = {rd_frame_n, wr_frame_n, sclk, sdin};

  ascr_sync #(.N(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (pin_raw),
    .q    (pin_lvl),
    .fall (pin_fall)
  );

  ascr_shift #(.W(CFG_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .shift_en(pin_fall[1]),
    .bit_in  (pin_lvl[0]),
    .word    (shift_word)
  );

  assign word_in = cfg_t'(shift_word);

  ascr_commit u_commit (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .commit_stb(pin_fall[2]),
    .word_in   (word_in),
    .addr_pin  (addr_pin),
    .conv_done (conv_done),
    .rd_active (~pin_lvl[3]),
    .cfg       (cfg),
    .acc       (wr_accept),
    .owner     (bus_owner),
    .oe        (sdo_oe)
  );

  ascr_decode u_decode (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cfg    (cfg),
    .in_mode(in_mode),
    .chan   (chan_sel)
  );

  assign pwr_mode = cfg.pwr;
  assign ext_ref  = cfg.ext;
  assign conv_req = cfg.conv;

endmodule

// File: tb/addr_serial_cfg_bench.sv
module addr_serial_cfg_bench;

  logic clk = 1'b0;
  logic rst_n, sclk, sdin, wr_frame_n, rd_frame_n, addr_pin, conv_done;
  logic [1:0] pwr_mode, in_mode;
  logic [2:0] chan_sel;
  logic ext_ref, conv_req, wr_accept, bus_owner, sdo_oe;

  int n_run = 0;
  int n_fail = 0;
  int n_acc = 0;
  bit done = 1'b0;
  logic [10:0] exp_q [$];

  always #4 clk = ~clk;

  addr_serial_cfg u_addr_serial_cfg (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin),
    .wr_frame_n(wr_frame_n), .rd_frame_n(rd_frame_n), .addr_pin(addr_pin),
    .conv_done(conv_done), .pwr_mode(pwr_mode), .ext_ref(ext_ref),
    .conv_req(conv_req), .in_mode(in_mode), .chan_sel(chan_sel),
    .wr_accept(wr_accept), .bus_owner(bus_owner), .sdo_oe(sdo_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input bit a, input bit [1:0] pd, input bit r8,
                                    input bit pr, input bit [2:0] ch, input bit cv,
                                    input bit ex);
    return {a, pd, r8, pr, ch, cv, ex};
  endfunction

  function automatic logic [1:0] exp_mode(input logic [9:0] w);
    if (w[5]) return 2'b10;
    return w[6] ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [9:0] outs_now();
    return {1'b0, pwr_mode, in_mode, chan_sel, conv_req, ext_ref};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      sdin = bits[i];
      tick(4);
      sclk = 1'b0;
      tick(4);
      sclk = 1'b1;
    end
  endtask

  // Driver: shift, strobe, push expectation when the address matches.
  task automatic send(input logic [9:0] w, input int junk, input bit collide);
    shift_bits({6'b101101, w}, 10 + junk);
    tick(2);
    if (w[9] == addr_pin) exp_q.push_back({~rd_frame_n, w});
    wr_frame_n = 1'b0;
    if (collide) begin
      @(posedge clk); @(posedge clk);
      @(negedge clk) conv_done = 1'b1;
      @(negedge clk) conv_done = 1'b0;
      tick(6);
    end else begin
      tick(8);
    end
    wr_frame_n = 1'b1;
    tick(4);
  endtask

  // Monitor: compare each accepted word against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && wr_accept) begin
      n_acc++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected accept", 1, 0);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        check(pwr_mode == e[8:7], "R2 pwr_mode", pwr_mode, e[8:7]);
        check(ext_ref == e[0], "R2 ext_ref", ext_ref, e[0]);
        check(conv_req == e[1], "R8 conv_req", conv_req, e[1]);
        check(chan_sel == e[4:2], "R7 chan_sel", chan_sel, e[4:2]);
        check(in_mode == exp_mode(e[9:0]), "R7 in_mode", in_mode, exp_mode(e[9:0]));
        check(bus_owner == 1'b1, "R6 owner on accept", bus_owner, 1);
        check(sdo_oe == e[10], "R9 oe at accept", sdo_oe, e[10]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0] snap;
    int acc0;
    rst_n = 1'b0; sclk = 1'b1; sdin = 1'b0; wr_frame_n = 1'b1;
    rd_frame_n = 1'b1; addr_pin = 1'b1; conv_done = 1'b0;
    tick(3);
    // R1 reset state
    check({pwr_mode, ext_ref, conv_req, in_mode, chan_sel} == 0, "R1 cfg zero",
          {pwr_mode, ext_ref, conv_req, in_mode, chan_sel}, 0);
    check({wr_accept, bus_owner, sdo_oe} == 0, "R1 flags low",
          {wr_accept, bus_owner, sdo_oe}, 0);
    rst_n = 1'b1;
    tick(6);
    check(pwr_mode == 2'b00, "R1 powered down", pwr_mode, 0);

    // R2 leading junk bits discarded; R7 single-ended
    send(mk(1, 2'b11, 0, 0, 3'd5, 0, 1), 3, 0);
    // R7 reference to input 8
    send(mk(1, 2'b01, 1, 0, 3'd2, 0, 0), 0, 0);
    // R7 paired ignores bit 6; R8 convert request set
    send(mk(1, 2'b10, 1, 1, 3'd7, 1, 1), 6, 0);
    check(conv_req == 1'b1, "R8 conv set", conv_req, 1);

    // R8 done pulse clears request only
    snap = outs_now();
    conv_done = 1'b1; tick(1); conv_done = 1'b0; tick(1);
    check(conv_req == 1'b0, "R8 conv cleared", conv_req, 0);
    check((outs_now() | 10'h002) == snap, "R4 others held", outs_now(), snap);

    // R4 idle hold
    snap = outs_now();
    tick(30);
    check(outs_now() == snap, "R4 idle hold", outs_now(), snap);

    // R9 read while owner
    rd_frame_n = 1'b0; tick(6);
    check(sdo_oe == 1'b1, "R9 oe while owner", sdo_oe, 1);
    rd_frame_n = 1'b1; tick(6);
    check(sdo_oe == 1'b0, "R9 oe off after read", sdo_oe, 0);

    // R5 R6 mismatched word during a read
    snap = outs_now(); acc0 = n_acc;
    rd_frame_n = 1'b0;
    send(mk(0, 2'b11, 0, 1, 3'd1, 1, 0), 0, 0);
    check(n_acc == acc0, "R5 no accept", n_acc, acc0);
    check(outs_now() == snap, "R5 cfg unchanged", outs_now(), snap);
    check(bus_owner == 1'b0, "R6 owner lost", bus_owner, 0);
    check(sdo_oe == 1'b0, "R9 oe dropped", sdo_oe, 0);
    rd_frame_n = 1'b1; tick(4);
    rd_frame_n = 1'b0; tick(6);
    check(sdo_oe == 1'b0, "R9 no drive when not owner", sdo_oe, 0);

    // R9 write and read in the same frame (oe compared at accept)
    send(mk(1, 2'b11, 1, 0, 3'd0, 0, 0), 0, 0);
    check(bus_owner == 1'b1, "R6 owner regained", bus_owner, 1);
    rd_frame_n = 1'b1; tick(6);

    // R8 done and commit on the same edge: new request wins
    send(mk(1, 2'b01, 0, 1, 3'd4, 1, 1), 0, 1);
    check(conv_req == 1'b1, "R8 commit beats done", conv_req, 1);

    // R3 R5 other strap value
    addr_pin = 1'b0; tick(2);
    send(mk(0, 2'b10, 0, 0, 3'd6, 0, 1), 0, 0);
    snap = outs_now(); acc0 = n_acc;
    send(mk(1, 2'b11, 1, 1, 3'd3, 1, 0), 0, 0);
    check(n_acc == acc0, "R5 strap 0 rejects", n_acc, acc0);
    check(outs_now() == snap, "R5 strap 0 cfg kept", outs_now(), snap);

    tick(4);
    check(exp_q.size() == 0, "R3 all accepts seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule